// File: doc/BRIEF.md
# Granule-Wise 2x2 Integer Matrix Multiply-Accumulate Unit

This unit views a wide vector as a row of independent 128-bit granules. Each granule holds four signed 32-bit elements that form a row-major 2x2 matrix. There are three such vectors: an accumulator, a left operand and a right operand. For every granule the unit adds the product of the left matrix and the transpose of the right matrix into the accumulator. This means both factors of each dot product come from rows: a row of the left matrix meets a row of the right matrix.

A single pulse on `start` captures all three vectors. One multiplier pair per granule then produces one output element per cycle for four cycles, so all granules advance in lockstep. When the fourth element is ready, the complete result vector appears on `acc_out` and `done` pulses for one cycle. The result register keeps its value until the next operation completes. A new request is taken only while the unit is idle.

Top module: `gmmla_unit`

## Requirements
- R1: Within each granule, element i occupies bits [32*i+31 : 32*i], so element 0 is the least significant. Granule g occupies bits [128*g+127 : 128*g] of every vector, so granule 0 is the least significant.
- R2: Result element 0 of a granule equals acc element 0 + left0*right0 + left1*right1.
- R3: Result element 1 of a granule equals acc element 1 + left0*right2 + left1*right3.
- R4: Result element 2 of a granule equals acc element 2 + left2*right0 + left3*right1.
- R5: Result element 3 of a granule equals acc element 3 + left2*right2 + left3*right3.
- R6: Each granule's result depends only on that granule's three inputs. All granules use the same index pattern.
- R7: Elements are two's-complement 32-bit values. Every product and sum wraps modulo 2^32.
- R8: Call the clock edge that samples `start` high while the unit is idle edge 0. Then `done` is high for exactly one cycle, beginning at edge 4, and `acc_out` holds the new result from edge 4 on.
- R9: A `start` pulse sampled while an operation is in progress is ignored. The operation in progress still completes with the captured inputs, and no extra `done` follows.
- R10: `acc_out` changes only at an edge that raises `done`. Input changes without an accepted `start` leave it untouched.
- R11: While reset (`rst_n` low) is applied, `acc_out` is all zeros and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| acc_in | input | 128*NUM_GRAN | Accumulator vector |
| lhs_in | input | 128*NUM_GRAN | Left operand vector |
| rhs_in | input | 128*NUM_GRAN | Right operand vector |
| acc_out | output | 128*NUM_GRAN | Result vector, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with NUM_GRAN set to 3. This gives an outer granule, a middle granule and a top granule, so a placement or crosstalk error shows up at either edge of the vector and also in the middle. Each table pattern is rotated across the three granules, so every granule sees different data in the same run. A single-element pattern pins the exact bit position of each element. Operands near the 32-bit limits exercise the wrap rule.

// File: rtl/gmmla_unit.sv
module gmmla_unit #(
  parameter int NUM_GRAN = 2,
  parameter int EW       = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NUM_GRAN*4*EW-1:0] acc_in,
  input  logic [NUM_GRAN*4*EW-1:0] lhs_in,
  input  logic [NUM_GRAN*4*EW-1:0] rhs_in,
  output logic [NUM_GRAN*4*EW-1:0] acc_out,
  output logic                  done
);
  localparam int GW = 4 * EW;
  localparam int VW = NUM_GRAN * GW;

  logic [VW-1:0] work, nxt_work, lhs_q, rhs_q;
  logic [1:0]    step;
  logic          busy;
  logic [EW-1:0] elem_sum [NUM_GRAN];

  wire row = step[1];
  wire col = step[0];

  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_gran
    logic [EW-1:0] la, lb, ra, rb, pa, pb;
    assign la = row ? lhs_q[g*GW + 2*EW +: EW] : lhs_q[g*GW +: EW];
    assign lb = row ? lhs_q[g*GW + 3*EW +: EW] : lhs_q[g*GW + EW +: EW];
    assign ra = col ? rhs_q[g*GW + 2*EW +: EW] : rhs_q[g*GW +: EW];
    assign rb = col ? rhs_q[g*GW + 3*EW +: EW] : rhs_q[g*GW + EW +: EW];
    assign pa = la * ra;
    assign pb = lb * rb;
    assign elem_sum[g] = work[g*GW + int'(step)*EW +: EW] + pa + pb;
  end

  always_comb begin
    nxt_work = work;
    for (int g = 0; g < NUM_GRAN; g++)
      nxt_work[g*GW + int'(step)*EW +: EW] = elem_sum[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      step    <= 2'd0;
      done    <= 1'b0;
      acc_out <= '0;
      work    <= '0;
      lhs_q   <= '0;
      rhs_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          step  <= 2'd0;
          work  <= acc_in;
          lhs_q <= lhs_in;
          rhs_q <= rhs_in;
        end
      end else begin
        work <= nxt_work;
        step <= step + 2'd1;
        if (step == 2'd3) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          acc_out <= nxt_work;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == 2'd3) |=> (done && !busy));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_out) |-> done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != 2'd3 && start) |=> (busy && step == $past(step) + 2'd1));

  // R9
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lhs_q) && $stable(rhs_q)));
endmodule

// File: tb/gmmla_unit_bench.sv
module gmmla_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 3;
  localparam int VW = NG * 128;
  localparam int NPAT = 6;

  // each row: acc0..3, lhs0..3, rhs0..3 (element 0 first)
  localparam logic [31:0] PAT [NPAT][12] = '{
    '{32'd0, 32'd0, 32'd0, 32'd0, 32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6, 32'd7, 32'd8},
    '{32'd10, 32'd20, 32'd30, 32'd40, 32'd1, 32'd0, 32'd0, 32'd1, 32'd9, 32'd8, 32'd7, 32'd6},
    '{32'hFFFFFFFF, 32'd5, 32'hFFFFFFFE, 32'd100, 32'hFFFFFFFD, 32'd4, 32'd2, 32'hFFFFFFFF,
      32'd3, 32'hFFFFFFFB, 32'd6, 32'd2},
    '{32'h7FFFFFFF, 32'h80000000, 32'd1, 32'd0, 32'h7FFFFFFF, 32'd2, 32'h10000, 32'h10000,
      32'h7FFFFFFF, 32'd3, 32'h10000, 32'h10000},
    '{32'd1000, 32'd2000, 32'd3000, 32'd4000, 32'd11, 32'd13, 32'd17, 32'd19,
      32'd23, 32'd29, 32'd31, 32'd37},
    '{32'hDEADBEEF, 32'h12345678, 32'h0, 32'hCAFEF00D, 32'h01010101, 32'hFFFF0000,
      32'h00FF00FF, 32'h80000001, 32'h13579BDF, 32'h2468ACE0, 32'hFFFFFFFF, 32'h00000003}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VW-1:0] acc_in = '0, lhs_in = '0, rhs_in = '0;
  logic [VW-1:0] acc_out;
  logic done;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  gmmla_unit #(.NUM_GRAN(NG)) u_gmmla_unit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .acc_in(acc_in), .lhs_in(lhs_in), .rhs_in(rhs_in),
    .acc_out(acc_out), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, l, r);
    logic [VW-1:0] res;
    res = '0;
    for (int g = 0; g < NG; g++)
      for (int k = 0; k < 4; k++) begin
        int rw, cl;
        rw = k / 2;
        cl = k % 2;
        res[g*128 + k*32 +: 32] = a[g*128 + k*32 +: 32]
          + l[g*128 + (2*rw)*32 +: 32] * r[g*128 + (2*cl)*32 +: 32]
          + l[g*128 + (2*rw+1)*32 +: 32] * r[g*128 + (2*cl+1)*32 +: 32];
      end
    return res;
  endfunction

  task automatic chk_vec(input string req, input logic [VW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s acc_out actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s done actual=%b expected=%b", req, act, exp);
    end
  endtask

  // issues one operation and checks R8 timing; leaves the bench at the negedge after edge 4
  task automatic run_op(input logic [VW-1:0] a, l, r, input string req, input bit poke_busy);
    @(negedge clk);
    acc_in = a; lhs_in = l; rhs_in = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_bit("R8", done, 1'b0);
    for (int i = 0; i < 3; i++) begin
      if (poke_busy && i == 0) begin
        acc_in = ~a; lhs_in = ~l; rhs_in = r + 1; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk_bit("R8", done, 1'b0);
    end
    @(negedge clk);
    chk_bit("R8", done, 1'b1);
    chk_vec(req, acc_out, model(a, l, r));
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, l, r, held;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk_vec("R11", acc_out, '0);
    chk_bit("R11", done, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // table walk: pattern rotated per granule (R2 R3 R4 R5 R6 R7)
    for (int t = 0; t < NPAT; t++) begin
      a = '0; l = '0; r = '0;
      for (int g = 0; g < NG; g++)
        for (int k = 0; k < 4; k++) begin
          a[g*128 + k*32 +: 32] = PAT[(t+g)%NPAT][k];
          l[g*128 + k*32 +: 32] = PAT[(t+g)%NPAT][4+k];
          r[g*128 + k*32 +: 32] = PAT[(t+g)%NPAT][8+k];
        end
      run_op(a, l, r, "R2_R3_R4_R5_R6_R7", 1'b0);
    end

    // R1 R2: lhs0=1, rhs0=5 in granule 0 -> bits [31:0] = 5 only
    a = '0; l = '0; r = '0;
    l[31:0] = 32'd1; r[31:0] = 32'd5;
    run_op(a, l, r, "R1", 1'b0);
    chk_vec("R1", acc_out, {{(VW-32){1'b0}}, 32'd5});

    // R1 R3: lhs1=1, rhs3=7 in top granule -> element 1 of top granule = 7
    a = '0; l = '0; r = '0;
    l[(NG-1)*128 + 32 +: 32] = 32'd1; r[(NG-1)*128 + 96 +: 32] = 32'd7;
    run_op(a, l, r, "R3", 1'b0);
    chk_vec("R1", acc_out, VW'(32'd7) << ((NG-1)*128 + 32));

    // R4 R5: only middle granule lhs2/lhs3 active, other granules stay at acc value (R6)
    a = '0; l = '0; r = '0;
    a[31:0] = 32'd42;
    l[128 + 64 +: 32] = 32'd3; l[128 + 96 +: 32] = 32'd2;
    r[128 +: 32] = 32'd4; r[128 + 32 +: 32] = 32'd5; r[128 + 64 +: 32] = 32'd6; r[128 + 96 +: 32] = 32'd1;
    run_op(a, l, r, "R4_R5_R6", 1'b0);

    // R7: (-1)*(-1) + 0x7FFFFFFF*2 wraps
    a = '0; l = '0; r = '0;
    l[31:0] = 32'hFFFFFFFF; r[31:0] = 32'hFFFFFFFF;
    l[63:32] = 32'h7FFFFFFF; r[63:32] = 32'd2;
    run_op(a, l, r, "R7", 1'b0);
    chk_vec("R7", acc_out, {{(VW-32){1'b0}}, 32'hFFFFFFFF});

    // R9: start during busy with other data is ignored
    a = '0; l = '0; r = '0;
    for (int k = 0; k < 4; k++) begin
      l[k*32 +: 32] = 32'(k + 2); r[k*32 +: 32] = 32'(3 * k + 1); a[k*32 +: 32] = 32'(k);
    end
    run_op(a, l, r, "R9", 1'b1);
    held = acc_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_bit("R9", done, 1'b0);
    end
    chk_vec("R9", acc_out, held);

    // R10: inputs change without start, output holds
    acc_in = '1; lhs_in = '1; rhs_in = '1;
    repeat (8) @(negedge clk);
    chk_vec("R10", acc_out, held);
    chk_bit("R10", done, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule